// File: doc/BRIEF.md
# Power-of-Two Codebook Term Selector and Dot-Product Accumulator

This block computes one output value of a multiplier-free convolution layer. Weights come as short index words, not as numbers. Each weight has N_SUB sub-index fields of IDX_W bits. Each field names one power-of-two component: zero, or plus or minus the activation shifted right by some amount. The weight's product with an activation is therefore the sum of N_SUB such components. A separate unit outside this block builds the shifted copies of each activation and presents them on a term port. This block does three things:

- decodes every field;
- picks the matching shifted copy and applies its sign;
- sums all picks across C_PAR parallel channels in a registered adder tree.

An accumulator then adds up the tree results over as many channel groups as the output needs.

An output is framed by `start_i` on its first group and `last_i` on its final group. Both qualify a cycle that has `valid_i` high. A new output may begin in the cycle right after the previous output's last group, with no gap. The finished sum appears on `sum_o` together with a one-cycle `done_o` pulse. It then stays on `sum_o` until the next pulse.

Top module: `pow2_term_accum`

## Requirements
- R1: A sub-index field holding code 0 contributes exactly zero, whatever the activation of its channel.
- R2: A nonzero code c in field 0 contributes the shifted term of index (c-1)>>1, taken positive when c is odd and negated when c is even.
- R3: Field n (bits [(ch*N_SUB+n)*IDX_W +: IDX_W] of `wgt_idx_i`) uses term index (c-1)>>1 + n. Each sub-codebook is therefore offset by its field number. Term k of channel ch sits at bits [(ch*NSHIFT+k)*TERM_W +: TERM_W] of `terms_i`.
- R4: The terms are signed two's-complement values and are sign-extended before selection. Term k is expected to hold the activation arithmetically shifted right by k.
- R5: The result of a single-group output equals the sum, over all channels and all fields, of the selected signed components.
- R6: A group accepted with `start_i` high begins a new sum from zero. Later groups of the same output add to it. Nothing from earlier outputs remains in the result.
- R7: For an output, `done_o` is high for exactly one cycle, DEPTH+1 clock edges after the edge that accepted its `last_i` group, where DEPTH = clog2(C_PAR*N_SUB). `sum_o` changes only together with `done_o`.
- R8: For up to MAX_GROUPS groups with every term at its most negative value, the result is exact and does not wrap.
- R9: While reset is applied and after it is released, `done_o` is low and `sum_o` is zero until the first result.
- R10: Cycles with `valid_i` low have no effect on any result, whatever values `wgt_idx_i` and `terms_i` carry in them.
- R11: Outputs presented back to back, one group after another with no idle cycle, each produce their own correct result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| valid_i | input | 1 | A channel group is present on the data inputs this cycle |
| start_i | input | 1 | This group is the first one of a new output |
| last_i | input | 1 | This group is the final one of the current output |
| wgt_idx_i | input | C_PAR*N_SUB*IDX_W | Sub-index fields of all weights in the group |
| terms_i | input | C_PAR*NSHIFT*TERM_W | Shifted activation terms per channel, NSHIFT = 2^(IDX_W-1)+N_SUB-1 |
| done_o | output | 1 | One-cycle pulse: a finished sum is on `sum_o` |
| sum_o | output | TERM_W+1+DEPTH+clog2(MAX_GROUPS)+1 | Signed result of the most recent output |

## Verification
The assertions take for granted that `start_i` and `last_i` are never raised without `valid_i`. They also assume an output never spans more than MAX_GROUPS groups, because the magnitude bound on `sum_o` rests on that limit. The bench keeps to these rules:

- it drives framing bits only inside valid groups;
- it draws group counts from 1 to MAX_GROUPS;
- it fills idle cycles with random weight and term data but holds all framing low.

It feeds every term from the arithmetic shift of a legal TERM_W-bit activation, as R4 expects.

// File: rtl/pow2_acc_pkg.sv
package pow2_acc_pkg;

  // Control that travels beside the data through every pipeline stage.
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } ctl_t;

  // Shift level of a nonzero sub-index code within its own sub-codebook.
  function automatic int unsigned code_level(int unsigned code);
    return (code - 1) >> 1;
  endfunction

  // Even nonzero codes select the negated term.
  function automatic logic code_negative(int unsigned code);
    return ((code % 2) == 0);
  endfunction

endpackage

// File: rtl/pow2_rst_sync.sv
module pow2_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/pow2_term_pick.sv
module pow2_term_pick
  import pow2_acc_pkg::*;
#(
  parameter int unsigned N_SUB  = 2,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned TERM_W = 8,
  parameter int unsigned NSHIFT = 5,
  parameter int unsigned SEL_W  = TERM_W + 1
) (
  input  logic [N_SUB*IDX_W-1:0]   idx_i,
  input  logic [NSHIFT*TERM_W-1:0] terms_i,
  output logic signed [SEL_W-1:0]  sel_o [N_SUB]
);

  for (genvar n = 0; n < N_SUB; n++) begin : g_sub
    logic [IDX_W-1:0]        code;
    logic signed [SEL_W-1:0] mag;
    int unsigned             want;

    assign code = idx_i[n*IDX_W +: IDX_W];

    always_comb begin
      want = code_level(32'(code)) + 32'(n);
      mag  = '0;
      for (int k = 0; k < int'(NSHIFT); k++) begin
        if ((code != '0) && (want == 32'(k))) begin
          mag = SEL_W'(signed'(terms_i[k*TERM_W +: TERM_W]));
        end
      end
    end

    always_comb begin
      if ((code != '0) && code_negative(32'(code))) begin
        sel_o[n] = -mag;
      end else begin
        sel_o[n] = mag;
      end
    end
  end

endmodule

// File: rtl/pow2_add_tree.sv
module pow2_add_tree
  import pow2_acc_pkg::*;
#(
  parameter int unsigned IN_W  = 9,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned NPAD  = 2 ** DEPTH,
  localparam int unsigned OUT_W = IN_W + DEPTH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  leaf_i [NPAD],
  input  ctl_t                    ctl_i,
  output logic signed [OUT_W-1:0] sum_o,
  output ctl_t                    ctl_o
);

  // Heap layout: node i (1..NPAD-1) lives at index i-1, children 2i and 2i+1.
  logic signed [OUT_W-1:0] heap_q [NPAD-1];
  logic signed [OUT_W-1:0] heap_d [NPAD-1];
  ctl_t                    ctl_q  [DEPTH];
  ctl_t                    ctl_d  [DEPTH];
  logic [DEPTH-1:0]        stage_en;

  always_comb begin
    stage_en[0] = ctl_i.vld;
    for (int s = 1; s < int'(DEPTH); s++) begin
      stage_en[s] = ctl_q[s-1].vld;
    end
    ctl_d[0] = ctl_i;
    for (int s = 1; s < int'(DEPTH); s++) begin
      ctl_d[s] = ctl_q[s-1];
    end
  end

  for (genvar i = 1; i < NPAD; i++) begin : g_node
    localparam int unsigned STAGE = DEPTH - $clog2(i + 1) + 1;
    logic signed [OUT_W-1:0] lhs;
    logic signed [OUT_W-1:0] rhs;

    if (2 * i >= NPAD) begin : g_leaf
      assign lhs = OUT_W'(leaf_i[2*i-NPAD]);
      assign rhs = OUT_W'(leaf_i[2*i+1-NPAD]);
    end else begin : g_inner
      assign lhs = heap_q[2*i-1];
      assign rhs = heap_q[2*i];
    end

    assign heap_d[i-1] = stage_en[STAGE-1] ? (lhs + rhs) : heap_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NPAD) - 1; i++) begin
        heap_q[i] <= '0;
      end
      for (int s = 0; s < int'(DEPTH); s++) begin
        ctl_q[s] <= '0;
      end
    end else begin
      for (int i = 0; i < int'(NPAD) - 1; i++) begin
        heap_q[i] <= heap_d[i];
      end
      for (int s = 0; s < int'(DEPTH); s++) begin
        ctl_q[s] <= ctl_d[s];
      end
    end
  end

  assign sum_o = heap_q[0];
  assign ctl_o = ctl_q[DEPTH-1];

endmodule

// File: rtl/pow2_term_accum.sv
module pow2_term_accum
  import pow2_acc_pkg::*;
#(
  parameter int unsigned N_SUB      = 2,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned C_PAR      = 4,
  parameter int unsigned TERM_W     = 8,
  parameter int unsigned MAX_GROUPS = 16,
  localparam int unsigned NSHIFT = 2 ** (IDX_W - 1) + N_SUB - 1,
  localparam int unsigned NLEAF  = C_PAR * N_SUB,
  localparam int unsigned DEPTH  = $clog2(NLEAF),
  localparam int unsigned NPAD   = 2 ** DEPTH,
  localparam int unsigned SEL_W  = TERM_W + 1,
  localparam int unsigned TREE_W = SEL_W + DEPTH,
  localparam int unsigned ACC_W  = TREE_W + $clog2(MAX_GROUPS) + 1,
  localparam int unsigned WGT_W  = C_PAR * N_SUB * IDX_W,
  localparam int unsigned TRM_W  = C_PAR * NSHIFT * TERM_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    start_i,
  input  logic                    last_i,
  input  logic [WGT_W-1:0]        wgt_idx_i,
  input  logic [TRM_W-1:0]        terms_i,
  output logic                    done_o,
  output logic signed [ACC_W-1:0] sum_o
);

  logic rst_sync_n;

  pow2_rst_sync i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  // Selection: one picker per channel, flattened as ch*N_SUB+n, padded to NPAD.
  logic signed [SEL_W-1:0] pick_sel [NPAD];

  for (genvar ch = 0; ch < C_PAR; ch++) begin : g_chan
    logic signed [SEL_W-1:0] ch_sel [N_SUB];

    pow2_term_pick #(
      .N_SUB  (N_SUB),
      .IDX_W  (IDX_W),
      .TERM_W (TERM_W),
      .NSHIFT (NSHIFT),
      .SEL_W  (SEL_W)
    ) i_pick (
      .idx_i   (wgt_idx_i[ch*N_SUB*IDX_W +: N_SUB*IDX_W]),
      .terms_i (terms_i[ch*NSHIFT*TERM_W +: NSHIFT*TERM_W]),
      .sel_o   (ch_sel)
    );

    for (genvar n = 0; n < N_SUB; n++) begin : g_flat
      assign pick_sel[ch*N_SUB+n] = ch_sel[n];
    end
  end

  for (genvar p = NLEAF; p < NPAD; p++) begin : g_pad
    assign pick_sel[p] = '0;
  end

  // Stage 1 registers: selected components and framing.
  logic signed [SEL_W-1:0] leaf_q [NPAD];
  logic signed [SEL_W-1:0] leaf_d [NPAD];
  ctl_t                    ctl1_q;
  ctl_t                    ctl1_d;

  always_comb begin
    ctl1_d.vld   = valid_i;
    ctl1_d.first = valid_i & start_i;
    ctl1_d.last  = valid_i & last_i;
    for (int i = 0; i < int'(NPAD); i++) begin
      leaf_d[i] = valid_i ? pick_sel[i] : leaf_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl1_q <= '0;
      for (int i = 0; i < int'(NPAD); i++) begin
        leaf_q[i] <= '0;
      end
    end else begin
      ctl1_q <= ctl1_d;
      for (int i = 0; i < int'(NPAD); i++) begin
        leaf_q[i] <= leaf_d[i];
      end
    end
  end

  // Pipelined reduction across channels and fields.
  logic signed [TREE_W-1:0] tree_sum;
  ctl_t                     tree_ctl;

  pow2_add_tree #(
    .IN_W  (SEL_W),
    .DEPTH (DEPTH)
  ) i_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .leaf_i (leaf_q),
    .ctl_i  (ctl1_q),
    .sum_o  (tree_sum),
    .ctl_o  (tree_ctl)
  );

  // Accumulation over groups and result hold.
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] res_q;
  logic signed [ACC_W-1:0] res_d;
  logic                    done_q;
  logic                    done_d;

  always_comb begin
    acc_d  = acc_q;
    res_d  = res_q;
    done_d = 1'b0;
    if (tree_ctl.vld) begin
      acc_d = (tree_ctl.first ? '0 : acc_q) + ACC_W'(tree_sum);
      if (tree_ctl.last) begin
        res_d  = acc_d;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign sum_o  = res_q;

endmodule

// File: rtl/pow2_term_accum_chk.sv
module pow2_term_accum_chk #(
  parameter int unsigned N_SUB      = 2,
  parameter int unsigned C_PAR      = 4,
  parameter int unsigned TERM_W     = 8,
  parameter int unsigned MAX_GROUPS = 16,
  parameter int unsigned ACC_W      = 17
) (
  input logic                    clk_i,
  input logic                    rst_n,
  input logic                    valid_i,
  input logic                    start_i,
  input logic                    last_i,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] sum_o
);

  localparam int unsigned LAT   = $clog2(C_PAR * N_SUB) + 2;
  localparam longint      BOUND = longint'(MAX_GROUPS) * longint'(C_PAR * N_SUB)
                                  * (longint'(1) << (TERM_W - 1));

  // Own model of when each accepted final group must surface.
  logic [LAT-1:0] last_pipe_q;
  logic [LAT-1:0] last_pipe_d;

  always_comb begin
    last_pipe_d = {last_pipe_q[LAT-2:0], valid_i & last_i};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      last_pipe_q <= '0;
    end else begin
      last_pipe_q <= last_pipe_d;
    end
  end

  p_done_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o == last_pipe_q[LAT-1]);

  p_sum_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> $stable(sum_o));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> ((longint'(sum_o) <= BOUND) && (longint'(sum_o) >= -BOUND)));

  p_start_framed_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_i |-> valid_i);

  p_last_framed_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    last_i |-> valid_i);

endmodule

bind pow2_term_accum pow2_term_accum_chk #(
  .N_SUB      (N_SUB),
  .C_PAR      (C_PAR),
  .TERM_W     (TERM_W),
  .MAX_GROUPS (MAX_GROUPS),
  .ACC_W      (ACC_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_sync_n),
  .valid_i (valid_i),
  .start_i (start_i),
  .last_i  (last_i),
  .done_o  (done_o),
  .sum_o   (sum_o)
);

// File: tb/test_pow2_term_accum.sv
module test_pow2_term_accum;

  localparam int N_SUB      = 2;
  localparam int IDX_W      = 3;
  localparam int C_PAR      = 4;
  localparam int TERM_W     = 8;
  localparam int MAX_GROUPS = 16;
  localparam int NSHIFT     = 2 ** (IDX_W - 1) + N_SUB - 1;
  localparam int DEPTH      = $clog2(C_PAR * N_SUB);
  localparam int ACC_W      = TERM_W + 1 + DEPTH + $clog2(MAX_GROUPS) + 1;
  localparam int WGT_W      = C_PAR * N_SUB * IDX_W;
  localparam int TRM_W      = C_PAR * NSHIFT * TERM_W;
  localparam int CLK_PERIOD = 10;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    valid;
  logic                    start;
  logic                    last;
  logic [WGT_W-1:0]        wgt;
  logic [TRM_W-1:0]        trm;
  logic                    done;
  logic signed [ACC_W-1:0] sum;

  pow2_term_accum #(
    .N_SUB      (N_SUB),
    .IDX_W      (IDX_W),
    .C_PAR      (C_PAR),
    .TERM_W     (TERM_W),
    .MAX_GROUPS (MAX_GROUPS)
  ) i_pow2_term_accum (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid),
    .start_i   (start),
    .last_i    (last),
    .wgt_idx_i (wgt),
    .terms_i   (trm),
    .done_o    (done),
    .sum_o     (sum)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit running = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  longint exp_sum_q [$];
  int     exp_cyc_q [$];
  string  exp_tag_q [$];

  int acts  [C_PAR];
  int codes [C_PAR][N_SUB];

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint field_val(input int code, input int n, input int a);
    int     sh;
    longint t;
    if (code == 0) return 0;
    sh = (code - 1) / 2 + n;
    t  = longint'(a >>> sh);
    return ((code % 2) == 0) ? -t : t;
  endfunction

  function automatic longint group_val();
    longint s = 0;
    for (int ch = 0; ch < C_PAR; ch++)
      for (int n = 0; n < N_SUB; n++)
        s += field_val(codes[ch][n], n, acts[ch]);
    return s;
  endfunction

  task automatic send_group(input bit first, input bit fin, input string tag,
                            inout longint run);
    @(negedge clk);
    for (int ch = 0; ch < C_PAR; ch++) begin
      for (int k = 0; k < NSHIFT; k++)
        trm[(ch*NSHIFT+k)*TERM_W +: TERM_W] = TERM_W'(acts[ch] >>> k);
      for (int n = 0; n < N_SUB; n++)
        wgt[(ch*N_SUB+n)*IDX_W +: IDX_W] = IDX_W'(codes[ch][n]);
    end
    valid = 1'b1;
    start = first;
    last  = fin;
    run   = first ? group_val() : run + group_val();
    if (fin) begin
      exp_sum_q.push_back(run);
      exp_cyc_q.push_back(cyc + DEPTH + 2);
      exp_tag_q.push_back(tag);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    valid = 1'b0;
    start = 1'b0;
    last  = 1'b0;
    wgt   = WGT_W'({$urandom(), $urandom()});
    for (int w = 0; w < TRM_W; w += 32) trm[w +: 32] = $urandom();
  endtask

  function automatic int rand_act();
    return int'($urandom_range(255)) - 128;
  endfunction

  // Result monitor: value and arrival cycle of every done pulse.
  always @(negedge clk) begin
    if (running && done) begin
      if (exp_sum_q.size() == 0) begin
        check("R7 unexpected done", 1, 0);
      end else begin
        check({exp_tag_q[0], " sum"}, longint'(sum), exp_sum_q[0]);
        check("R7 done cycle", cyc, exp_cyc_q[0]);
        void'(exp_sum_q.pop_front());
        void'(exp_cyc_q.pop_front());
        void'(exp_tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R7 watchdog expired actual=hang expected=completion");
    finish_run();
  end

  initial begin
    longint run = 0;
    int     set_a [7] = '{-128, -77, -1, 0, 1, 53, 127};
    rst_n = 1'b0;
    valid = 1'b0;
    start = 1'b0;
    last  = 1'b0;
    wgt   = '0;
    trm   = '0;
    repeat (3) @(negedge clk);
    check("R9 done in reset", done, 0);
    check("R9 sum in reset", sum, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 done after reset", done, 0);
    check("R9 sum after reset", sum, 0);
    running = 1'b1;

    // Single-field sweep, back to back: every channel, field, code and
    // a spread of activations; other channels carry nonzero activations
    // under code 0 (R1, R2, R3, R4, R11).
    for (int ch = 0; ch < C_PAR; ch++)
      for (int n = 0; n < N_SUB; n++)
        for (int code = 0; code < 2 ** IDX_W; code++)
          for (int ai = 0; ai < 7; ai++) begin
            for (int c2 = 0; c2 < C_PAR; c2++) begin
              acts[c2] = rand_act();
              for (int n2 = 0; n2 < N_SUB; n2++) codes[c2][n2] = 0;
            end
            acts[ch]        = set_a[ai];
            codes[ch][n]    = code;
            send_group(1'b1, 1'b1,
                       (code == 0) ? "R1 R11" : ((n == 0) ? "R2 R4 R11" : "R3 R4 R11"),
                       run);
          end

    // Multi-group outputs with random codes, sizes and idle gaps holding
    // garbage data (R5, R6, R10).
    for (int o = 0; o < 150; o++) begin
      int ng = 1 + int'($urandom_range(MAX_GROUPS - 1));
      for (int g = 0; g < ng; g++) begin
        for (int c2 = 0; c2 < C_PAR; c2++) begin
          acts[c2] = rand_act();
          for (int n2 = 0; n2 < N_SUB; n2++)
            codes[c2][n2] = int'($urandom_range(2 ** IDX_W - 1));
        end
        send_group(g == 0, g == ng - 1, (ng == 1) ? "R5 R10" : "R6 R10", run);
        if ($urandom_range(2) == 0) begin
          for (int k = 0; k <= int'($urandom_range(1)); k++) idle_cycle();
        end
      end
    end

    // Extreme magnitudes over the full group budget (R8).
    for (int pol = 0; pol < 2; pol++) begin
      for (int g = 0; g < MAX_GROUPS; g++) begin
        for (int c2 = 0; c2 < C_PAR; c2++) begin
          acts[c2] = -128;
          for (int n2 = 0; n2 < N_SUB; n2++) codes[c2][n2] = (pol == 0) ? 2 : 1;
        end
        send_group(g == 0, g == MAX_GROUPS - 1, "R8", run);
      end
    end

    idle_cycle();
    repeat (DEPTH + 4) @(negedge clk);
    check("R7 outstanding results", exp_sum_q.size(), 0);
    finish_run();
  end

endmodule